// File: doc/BRIEF.md
# Serial-Loaded Multi-Channel Wiper Register

This block holds a bank of 8-bit wiper codes and loads them from a three-wire serial link. The link has a serial clock, an active-low select and a data line. While the select is low, every rising edge of the serial clock pushes one data bit into an 11-bit word register. When the select returns high, the word is split into a 3-bit channel address and an 8-bit code. The code is stored in the one channel latch that the address names.

A serial output repeats each input bit eleven shifts later, so a second device wired behind this one receives the rest of a longer stream while the select stays low. The output is modelled as an open-drain pin: it is a drive-low enable, and when released the pin reads high. An asynchronous preset puts every channel back to midscale. A shutdown input releases the serial output and flags every channel as shut down.

All three serial inputs are synchronized into the system clock and edge-detected there. A parameter builds the bank with four or six channels.

Top module: `serial_wiper_bank`

## Requirements
- R1: A bit is shifted into the word register only on a rising serial-clock edge seen while the select is low. Serial-clock edges seen while the select is high change neither the register nor the serial output.
- R2: The word is sent MSB first and has 11 bits. The three address bits come first (bits 10..8), then the eight code bits (bits 7..0). A rising edge on the select stores the code into the addressed channel and leaves every other channel unchanged.
- R3: In the six-channel build, address codes 0 to 5 select channels 0 to 5 (the code value is the channel index). Codes 6 and 7 load no channel.
- R4: In the four-channel build, address codes 0 to 3 select channels 0 to 3. Codes 4 to 7 load no channel.
- R5: On each shift, the serial output latch takes the bit that was shifted in eleven shifts earlier. A latch value of 0 drives the pin low; a value of 1 releases it.
- R6: While the asynchronous preset input is low, every channel holds 0x80 and the serial output latch holds 0, whatever the clock is doing.
- R7: If a latch strobe comes while the preset is low, the preset wins and all channels stay at 0x80.
- R8: While the shutdown input is low, the serial output is released and every bit of the shutdown indication is 1. Otherwise the indication is all 0 and the channel codes are kept.
- R9: After reset, every channel is at 0x80, the serial output latch is 0 (pin driven low) and the word register is all zeros.
- R10: A select rise after fewer than eleven shifts latches the word register exactly as it stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, sampled in the system domain |
| sel_n | input | 1 | Active-low serial select |
| ser_in | input | 1 | Serial data input |
| preset_n | input | 1 | Asynchronous active-low preset to midscale |
| shdn_n | input | 1 | Active-low shutdown |
| ser_out_pull_low | output | 1 | Serial output drive-low enable (released reads high) |
| wiper_code | output | NUM_CH*CODE_W | Channel codes, channel 0 in the low byte |
| ch_shutdown | output | NUM_CH | Per-channel shutdown indication |

## Verification
The bench builds two copies side by side from the same serial lines. One uses NUM_CH=6, so address codes 4 and 5 reach real latches and codes 6 and 7 show the no-load path. The other uses NUM_CH=4, where the same codes 4 and 5 must leave every latch untouched. Running both on identical frames shows that the address decode follows the channel-count parameter and not a fixed map. The default SYNC_STAGES=2 sets the latency between a serial event and the register update, and the bench waits out that latency before it samples.

// File: rtl/serial_wiper_bank.sv
module serial_wiper_bank #(
  parameter int NUM_CH      = 4,
  parameter int CODE_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk,
  input  logic                     sel_n,
  input  logic                     ser_in,
  input  logic                     preset_n,
  input  logic                     shdn_n,
  output logic                     ser_out_pull_low,
  output logic [NUM_CH*CODE_W-1:0] wiper_code,
  output logic [NUM_CH-1:0]        ch_shutdown
);
  localparam int WORD_W = ADDR_W + CODE_W;
  localparam int LAST   = SYNC_STAGES - 1;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [SYNC_STAGES-1:0] clk_sync, sel_sync, din_sync;
  logic                   clk_q, sel_q;
  logic [WORD_W-1:0]      word_sr;
  logic                   out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= '0;
      sel_sync <= '1;
      din_sync <= '0;
      clk_q    <= 1'b0;
      sel_q    <= 1'b1;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], ser_clk};
      sel_sync <= {sel_sync[SYNC_STAGES-2:0], sel_n};
      din_sync <= {din_sync[SYNC_STAGES-2:0], ser_in};
      clk_q    <= clk_sync[LAST];
      sel_q    <= sel_sync[LAST];
    end
  end

  wire sel_high  = sel_sync[LAST];
  wire shift_en  = clk_sync[LAST] & ~clk_q & ~sel_high;
  wire sel_rise  = sel_high & ~sel_q;
  wire [ADDR_W-1:0] word_addr = word_sr[WORD_W-1 -: ADDR_W];
  wire [CODE_W-1:0] word_code = word_sr[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_sr <= '0;
    else if (shift_en) word_sr <= {word_sr[WORD_W-2:0], din_sync[LAST]};
  end

  always_ff @(posedge clk or negedge rst_n or negedge preset_n) begin
    if (!rst_n || !preset_n) out_q <= 1'b0;
    else if (shift_en)       out_q <= word_sr[WORD_W-1];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n or negedge preset_n) begin
      if (!rst_n || !preset_n)
        wiper_code[g*CODE_W +: CODE_W] <= MID;
      else if (sel_rise && word_addr == ADDR_W'(g))
        wiper_code[g*CODE_W +: CODE_W] <= word_code;
    end
  end

  assign ser_out_pull_low = shdn_n & ~out_q;
  assign ch_shutdown      = {NUM_CH{~shdn_n}};
endmodule

// File: rtl/serial_wiper_bank_chk.sv
module serial_wiper_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8,
  parameter int WORD_W = 11
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     preset_n,
  input logic                     shdn_n,
  input logic                     ser_out_pull_low,
  input logic [NUM_CH*CODE_W-1:0] wiper_code,
  input logic [NUM_CH-1:0]        ch_shutdown,
  input logic                     sel_high,
  input logic                     sel_rise,
  input logic                     shift_en,
  input logic [WORD_W-1:0]        word_sr,
  input logic                     out_q
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  p_no_shift_sel_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_high |=> $stable(word_sr));

  p_hold_without_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n || !preset_n)
    !sel_rise |=> $stable(wiper_code));

  p_out_delay_r5: assert property (@(posedge clk) disable iff (!rst_n || !preset_n)
    shift_en |=> out_q == $past(word_sr[WORD_W-1]));

  p_preset_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |-> (wiper_code == {NUM_CH{MID}}) && (ser_out_pull_low == shdn_n));

  p_shutdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> !ser_out_pull_low && (&ch_shutdown));

  p_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_n |-> ch_shutdown == '0);
endmodule

bind serial_wiper_bank serial_wiper_bank_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .shdn_n(shdn_n),
  .ser_out_pull_low(ser_out_pull_low), .wiper_code(wiper_code),
  .ch_shutdown(ch_shutdown), .sel_high(sel_high), .sel_rise(sel_rise),
  .shift_en(shift_en), .word_sr(word_sr), .out_q(out_q)
);

// File: tb/serial_wiper_bank_tb_top.sv
module serial_wiper_bank_tb_top;
  logic clk = 0, rst_n = 0, ser_clk = 0, sel_n = 1, ser_in = 0, preset_n = 1, shdn_n = 1;
  logic pl6, pl4;
  logic [47:0] w6;
  logic [31:0] w4;
  logic [5:0]  sd6;
  logic [3:0]  sd4;

  always #4 clk = ~clk;

  serial_wiper_bank #(.NUM_CH(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sel_n(sel_n), .ser_in(ser_in),
    .preset_n(preset_n), .shdn_n(shdn_n), .ser_out_pull_low(pl6),
    .wiper_code(w6), .ch_shutdown(sd6));
  serial_wiper_bank #(.NUM_CH(4)) dut4_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sel_n(sel_n), .ser_in(ser_in),
    .preset_n(preset_n), .shdn_n(shdn_n), .ser_out_pull_low(pl4),
    .wiper_code(w4), .ch_shutdown(sd4));

  int checks = 0, failures = 0;
  bit done = 0;
  bit q[$];
  bit out_exp;
  int exp6[6];
  int exp4[4];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_out(string tag);
    chk({tag, " out6"}, pl6, shdn_n ? !out_exp : 0);
    chk({tag, " out4"}, pl4, shdn_n ? !out_exp : 0);
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 6; i++) chk($sformatf("%s ch6_%0d", tag, i), w6[i*8 +: 8], exp6[i]);
    for (int i = 0; i < 4; i++) chk($sformatf("%s ch4_%0d", tag, i), w4[i*8 +: 8], exp4[i]);
    chk({tag, " shd6"}, sd6, shdn_n ? 0 : 6'h3f);
    chk({tag, " shd4"}, sd4, shdn_n ? 0 : 4'hf);
    check_out(tag);
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_mid();
    for (int i = 0; i < 6; i++) exp6[i] = 8'h80;
    for (int i = 0; i < 4; i++) exp4[i] = 8'h80;
    out_exp = 0;
  endtask

  task automatic model_latch();
    int a, d;
    a = q[0] * 4 + q[1] * 2 + q[2];
    d = 0;
    for (int i = 0; i < 8; i++) d = d * 2 + q[3 + i];
    if (a < 6) exp6[a] = d;
    if (a < 4) exp4[a] = d;
  endtask

  task automatic send_bit(bit b);
    ser_in = b;
    waitc(3);
    ser_clk = 1;
    if (!sel_n) begin
      q.push_back(b);
      out_exp = q.pop_front();
    end
    waitc(3);
    ser_clk = 0;
    waitc(3);
  endtask

  task automatic sel_low();
    sel_n = 0;
    waitc(3);
  endtask

  task automatic sel_up();
    sel_n = 1;
    model_latch();
    waitc(5);
  endtask

  task automatic send_word(int addr, int data);
    logic [10:0] w;
    w = {addr[2:0], data[7:0]};
    sel_low();
    for (int i = 10; i >= 0; i--) send_bit(w[i]);
    sel_up();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 11; i++) q.push_back(0);
    model_mid();
    waitc(5);
    rst_n = 1;
    waitc(5);
    check_all("R9 reset");

    send_word(0, 8'h11); send_word(1, 8'h22); send_word(2, 8'h33); send_word(3, 8'hC4);
    check_all("R2 ch0-3");
    send_word(4, 8'h5A); send_word(5, 8'hA5);
    check_all("R3 ch4-5");
    check_all("R4 four-ch ignores 4,5");
    send_word(6, 8'hFF); send_word(7, 8'h01);
    check_all("R3 codes 6,7 no load");

    send_word(2, 8'h6E);
    for (int i = 0; i < 5; i++) send_bit(1);
    check_all("R1 sel high no shift");
    sel_low();
    send_bit(1); send_bit(0); send_bit(1);
    sel_up();
    check_all("R10 short frame");

    sel_low();
    for (int i = 0; i < 22; i++) begin
      send_bit(((i * 7) % 5) < 2);
      check_out("R5 chain");
    end
    sel_up();
    check_all("R5 after chain");

    preset_n = 0;
    model_mid();
    waitc(2);
    check_all("R6 during preset");
    preset_n = 1;
    waitc(2);
    check_all("R6 after preset");

    send_word(1, 8'h3C);
    check_all("R2 reload");
    sel_low();
    for (int i = 10; i >= 0; i--) send_bit(i == 9 ? 1 : (i % 2));
    sel_n = 1;
    preset_n = 0;
    model_mid();
    waitc(8);
    preset_n = 1;
    waitc(3);
    check_all("R7 preset beats strobe");

    send_word(5, 8'h9D);
    shdn_n = 0;
    waitc(3);
    check_all("R8 shutdown");
    shdn_n = 1;
    waitc(3);
    check_all("R8 wake");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule